// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the main clock using two stages in series. A prescaler divides the main clock by 2, 4, 8 or 16, chosen by a 2-bit exponent field. A second stage divides the prescaled clock by twice one more than a 6-bit rate field. The shift engine uses the block's leading and trailing edge strobes to time its sampling and launching.

The rate field, the exponent field and the idle polarity are captured only while the block is disabled, so one transfer keeps one configuration. The shift engine asserts a run request for the length of a transfer. While the request is low, the serial clock rests at the idle polarity and both counters are held at zero. A half period lasts (rate+1)·(2<<exp) main-clock cycles. The fastest legal setting divides the main clock by 20 and the slowest divides it by 2048.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, sclk_o is 0 and lead_o and trail_o are 0.
- R2: While running, successive transitions of sclk_o are exactly (brg+1)·(2<<div) main-clock cycles apart.
- R3: The first transition of sclk_o occurs on the H-th rising clock edge at which en_i and run_i are both sampled high, where H is the half period from R2.
- R4: A captured rate value below 4 behaves exactly as 4.
- R5: While en_i or run_i is low, sclk_o holds the captured polarity, and it returns to that level on the first clock edge after run_i falls.
- R6: lead_o is high for exactly one cycle, in the cycle in which sclk_o has just left its idle level. trail_o is high for exactly one cycle, in the cycle in which sclk_o has just returned to idle.
- R7: div_i, brg_i and cpol_i are captured on every clock edge while en_i is low. Changes to them while en_i is high have no effect.
- R8: While en_i is low, run_i has no effect: sclk_o equals cpol_i from the previous edge and no strobe appears.
- R9: lead_o and trail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; configuration is captured while low |
| div_i | input | 2 | Prescale exponent, divides by 2<<div_i |
| brg_i | input | 6 | Rate value; second stage divides by 2·(brg_i+1), clamped to at least 4 |
| cpol_i | input | 1 | Idle level of the serial clock |
| run_i | input | 1 | Run request from the shift engine |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe when sclk_o leaves idle |
| trail_o | output | 1 | One-cycle strobe when sclk_o returns to idle |

## Verification
A stuck or misloaded prescaler or rate counter changes the spacing of sclk_o transitions, so it shows up within one half period, at most 1024 cycles, as a wrong first-edge delay or a wrong interval. Captured configuration that leaks while the block is enabled shows up as a changed half period or idle level on the very next run. A strobe with the wrong kind, or one that lasts two cycles, is visible in the cycle after the toggle. A counter not cleared when run_i falls shows up as a shortened first half period after the restart.

// File: rtl/spi_baud_pkg.sv
`timescale 1ns/1ps
package spi_baud_pkg;
  localparam int DIV_W   = 2;
  localparam int BRG_W   = 6;
  localparam int BRG_MIN = 4;
  // prescale counter holds up to (2 << max_div) - 1
  localparam int PRE_W   = 1 << DIV_W;
endpackage

// File: rtl/spi_baud_cfg.sv
`timescale 1ns/1ps
module spi_baud_cfg
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic [DIV_W-1:0] div_o,
  output logic [BRG_W-1:0] brg_o,
  output logic             cpol_o
);
  localparam logic [BRG_W-1:0] BrgFloor = BRG_W'(BRG_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      brg_o  <= BrgFloor;
      cpol_o <= 1'b0;
    end else if (!en_i) begin
      div_o  <= div_i;
      brg_o  <= (brg_i < BrgFloor) ? BrgFloor : brg_i;
      cpol_o <= cpol_i;
    end
  end

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> ($stable(div_o) && $stable(brg_o) && $stable(cpol_o)));
  p_brg_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brg_o >= BrgFloor);
endmodule

// File: rtl/spi_baud_prescale.sv
`timescale 1ns/1ps
module spi_baud_prescale
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  assign lim    = PRE_W'((32'd2 << div_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_pre_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  p_pre_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_baud_edge.sv
`timescale 1ns/1ps
module spi_baud_edge
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_q_i,
  input  logic             cpol_in_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [BRG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= '0;
      sclk_o  <= cpol_in_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      sclk_o  <= cpol_q_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == brg_i) begin
          cnt_q  <= '0;
          sclk_o <= ~sclk_o;
          // leaving idle is the leading edge
          if (sclk_o == cpol_q_i) lead_o  <= 1'b1;
          else                    trail_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));
  p_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o != cpol_q_i) && ($past(sclk_o) != sclk_o));
  p_trail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o == cpol_q_i) && ($past(sclk_o) != sclk_o));
  p_stop_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> (sclk_o == cpol_q_i) && !lead_o && !trail_o);
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= brg_i);
endmodule

// File: rtl/spi_baud_gen.sv
`timescale 1ns/1ps
module spi_baud_gen
  import spi_baud_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             cpol_q;
  logic             run;
  logic             tick;

  assign run = en_i && run_i;

  spi_baud_cfg u_cfg (
    .clk_i, .rst_ni, .en_i, .div_i, .brg_i, .cpol_i,
    .div_o(div_q), .brg_o(brg_q), .cpol_o(cpol_q)
  );

  spi_baud_prescale u_pre (
    .clk_i, .rst_ni, .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  spi_baud_edge u_edge (
    .clk_i, .rst_ni, .load_i(!en_i), .run_i(run), .tick_i(tick),
    .brg_i(brg_q), .cpol_q_i(cpol_q), .cpol_in_i(cpol_i),
    .sclk_o, .lead_o, .trail_o
  );

  p_dis_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lead_o && !trail_o && (sclk_o == $past(cpol_i)));
endmodule

// File: tb/spi_baud_gen_tb_top.sv
`timescale 1ns/1ps
module spi_baud_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cpol = 1'b0, run = 1'b0;
  logic [1:0] dv = '0;
  logic [5:0] br = 6'd4;
  logic sclk, lead, trail;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_baud_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(dv), .brg_i(br),
    .cpol_i(cpol), .run_i(run), .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
  );

  // div, brg, cpol, expected half period
  localparam int NV = 8;
  localparam int TD [NV] = '{0, 1, 2, 0, 3, 0, 0, 1};
  localparam int TB [NV] = '{4, 4, 9, 63, 4, 2, 0, 7};
  localparam int TC [NV] = '{0, 1, 0, 1, 0, 0, 1, 0};
  localparam int TH [NV] = '{10, 20, 80, 128, 80, 10, 10, 32};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int d, input int b, input int c);
    @(negedge clk);
    en = 1'b0; run = 1'b0;
    dv = 2'(d); br = 6'(b); cpol = 1'(c);
    @(negedge clk);
    chk(sclk == 1'(c) && !lead && !trail, "R8 idle while disabled", int'(sclk), c);
    en = 1'b1;
    @(negedge clk);
  endtask

  // counts edges from run start to first toggle, then to return to idle
  task automatic measure(input int idle, input int h, input string req);
    int n = 0, m = 0;
    run = 1'b1;
    do begin
      @(posedge clk); #2; n++;
    end while (sclk == 1'(idle) && n < 5000);
    chk(n == h, {req, " first edge (R3)"}, n, h);
    chk(lead && !trail, "R6 leading strobe", {lead, trail}, 2);
    do begin
      @(posedge clk); #2; m++;
      if (m == 1) chk(!lead && !trail, "R6 strobe one cycle", {lead, trail}, 0);
    end while (sclk != 1'(idle) && m < 5000);
    chk(m == h, {req, " half period (R2)"}, m, h);
    chk(trail && !lead, "R6 trailing strobe", {lead, trail}, 1);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk(sclk == 0 && !lead && !trail, "R1 reset state", int'(sclk), 0);
    #10 rst_n = 1'b1;

    // R8: run request while disabled has no effect
    @(negedge clk); cpol = 1'b1; run = 1'b1;
    repeat (30) begin
      @(negedge clk);
      chk(sclk == 1'b1 && !lead && !trail, "R8 run ignored while disabled", int'(sclk), 1);
    end
    run = 1'b0;

    // table walk: R2, R3, R4 (rows 5 and 6 clamp), R6
    for (int i = 0; i < NV; i++) begin
      setup(TD[i], TB[i], TC[i]);
      measure(TC[i], TH[i], (TB[i] < 4) ? "R4 clamp" : "R2 table");
      @(negedge clk); run = 1'b0;
    end

    // slowest legal setting
    setup(3, 63, 0);
    measure(0, 1024, "R2 slowest");
    @(negedge clk); run = 1'b0;

    // R7: inputs changed while enabled are ignored
    setup(0, 4, 0);
    dv = 2'd3; br = 6'd63; cpol = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0, "R7 polarity held", int'(sclk), 0);
    measure(0, 10, "R7 frozen config");
    @(negedge clk); run = 1'b0;

    // R5: stop mid period, idle return, clean restart
    setup(0, 4, 1);
    run = 1'b1;
    do @(posedge clk); while (sclk == 1'b1);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #2;
    chk(sclk == 1'b1, "R5 idle after stop", int'(sclk), 1);
    chk(!lead && !trail, "R5 no strobe on stop", {lead, trail}, 0);
    repeat (3) @(posedge clk);
    #2 chk(sclk == 1'b1, "R5 idle held", int'(sclk), 1);
    @(negedge clk);
    measure(1, 10, "R5 restart");
    @(negedge clk); run = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule